// File: doc/BRIEF.md
# Glitch-free clock output enable controller

This block sits between a bank of internal clock dividers and the pads that carry those clocks off the chip. For every channel it decides, cycle by cycle, whether the pad repeats its source clock or holds a programmed idle state. Two controls decide this. One is a chip-wide, active-high disable pin that shuts every channel. The other is a per-channel enable bit from the configuration registers, which can shut a channel on its own while the pin allows output. The number of channels is a parameter and defaults to ten.

Each channel has two settings of its own. The idle level can be driven low, driven high or left floating. The stop style is either period-completing, where a high pulse already in progress always finishes, or immediate, where the output is cut at once. Both control inputs are asynchronous to the channel clocks, so each channel resynchronises them in its own clock domain. A channel always restarts while its clock is low, so the first pulse after a restart has full width. While a channel is running, its pad follows the source clock combinationally. No register sits in the clock path, so channels fed from aligned sources stay aligned.

The outputs are a data bit and an output-enable bit per channel, ready for a tristate pad cell.

Top module: `clkout_gate_bank`

## Requirements
- R1: While `glob_dis` is high, every channel shows its idle state, whatever its enable bit. Once `glob_dis` has been high at two consecutive rising edges of a channel clock, that channel is idle by the following rising edge.
- R2: While `glob_dis` is low, a channel with a 0 in `chan_en` shows its idle state, and a channel with a 1 runs.
- R3: The idle state uses the 2-bit field `dis_level[2i+1:2i]` of channel i. 00 gives `pad_oe`=1 and `pad_data`=0. 01 gives `pad_oe`=1 and `pad_data`=1. 10 gives `pad_oe`=0 and `pad_data`=0. 11 behaves like 10.
- R4: With `sync_stop[i]`=1, a stop request first reaches the gate at the second rising edge of the channel clock after the request. The high phase that begins at that edge still completes, and the channel goes idle at the following falling edge.
- R5: With `sync_stop[i]`=0, the channel goes idle at the second rising edge after the stop request, with no wait for the falling edge. At that edge the output already shows the idle level instead of a high pulse.
- R6: A restart takes effect only at a falling edge, once the request has passed two rising edges. With an enable raised while the clock is low, the channel is still idle at the second rising edge and is running at the third.
- R7: A running channel drives `pad_oe`=1, and `pad_data` equals its source clock in both phases, with no added register stage.
- R8: While `rst` is high, and until an enable has been resynchronised and accepted at a falling edge, every channel shows its idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | N_CH | Source clock of each channel, from its divider |
| rst | input | 1 | Synchronous active-high reset, sampled in each channel clock domain |
| glob_dis | input | 1 | Asynchronous chip-wide disable, high shuts every channel |
| chan_en | input | N_CH | Per-channel enable bit from the configuration registers |
| sync_stop | input | N_CH | 1 = period-completing stop, 0 = immediate stop |
| dis_level | input | 2*N_CH | Idle-state code per channel: 00 low, 01 high, 10 or 11 floating |
| pad_data | output | N_CH | Data value toward the pad |
| pad_oe | output | N_CH | Output-enable toward the pad, 1 = driven |

## Verification
The most likely internal faults show up at a single edge. A gate register clocked on the wrong edge, or a missing synchroniser stage, moves the start or stop by half a period or a full period. This is checked by sampling both phases at the rising edges just before, at and just after the expected transition. A swapped stop style shows as a high pulse that is missing, or one that is too long, at the second rising edge after the request. A wrong idle decode shows at once as a wrong data or output-enable level on an idle channel. A synchroniser that fails to clear on reset shows as a channel running during reset.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;

    // idle-state code, two bits per channel
    typedef enum logic [1:0] {
        OFF_LOW  = 2'b00,
        OFF_HIGH = 2'b01,
        OFF_HIZ  = 2'b10,
        OFF_RSVD = 2'b11
    } off_lvl_e;

    // what one channel hands to its pad cell
    typedef struct packed {
        logic data;
        logic oe;
    } pad_drv_t;

    // raw control pair carried through the synchroniser
    typedef struct packed {
        logic glob_off;
        logic chan_on;
    } gate_req_t;

    localparam int REQ_W = $bits(gate_req_t);

    function automatic pad_drv_t off_drive(input off_lvl_e lvl);
        pad_drv_t d;
        case (lvl)
            OFF_LOW:  d = '{data: 1'b0, oe: 1'b1};
            OFF_HIGH: d = '{data: 1'b1, oe: 1'b1};
            default:  d = '{data: 1'b0, oe: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/clkout_gate_sync.sv
module clkout_gate_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/clkout_gate_chan.sv
module clkout_gate_chan
    import clkout_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     src_clk,
    input  logic     rst,
    input  logic     glob_off,
    input  logic     chan_on,
    input  logic     sync_stop,
    input  off_lvl_e off_lvl,
    output pad_drv_t drv
);

    gate_req_t req_raw;
    gate_req_t req_s;
    logic      allow;
    logic      gate_q;
    logic      active;

    assign req_raw = '{glob_off: glob_off, chan_on: chan_on};

    clkout_gate_sync #(
        .WIDTH (REQ_W),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(src_clk),
        .rst(rst),
        .d  (req_raw),
        .q  (req_s)
    );

    assign allow = req_s.chan_on & ~req_s.glob_off;

    // period boundary register: updates only while the clock is low
    always_ff @(negedge src_clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= allow;
    end

    // immediate style also cuts as soon as the synchronised request drops
    assign active = gate_q & (sync_stop | allow);

    always_comb begin
        if (active) drv = '{data: src_clk, oe: 1'b1};
        else        drv = off_drive(off_lvl);
    end

    // checker state: gate value seen during the high phase
    logic act_at_rise;
    always_ff @(posedge src_clk) begin
        if (rst) act_at_rise <= 1'b0;
        else     act_at_rise <= active;
    end

    AST_GLOBAL_OFF: assert property (@(posedge src_clk) disable iff (rst)
        ($past(glob_off) && $past(glob_off, 2)) |-> !active); // R1

    AST_REG_OFF: assert property (@(posedge src_clk) disable iff (rst)
        ($past(!chan_on) && $past(!chan_on, 2)) |-> !active); // R2

    AST_HIZ_QUIET: assert property (@(posedge src_clk) disable iff (rst)
        !drv.oe |-> !drv.data); // R3

    AST_SYNC_FULL_HIGH: assert property (@(negedge src_clk) disable iff (rst)
        (sync_stop && act_at_rise) |-> active); // R4

    AST_ENABLE_AT_BOUNDARY: assert property (@(posedge src_clk) disable iff (rst)
        $rose(active) |-> allow); // R6

endmodule

// File: rtl/clkout_gate_bank.sv
module clkout_gate_bank
    import clkout_gate_pkg::*;
#(
    parameter int N_CH        = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic [N_CH-1:0]   src_clk,
    input  logic              rst,
    input  logic              glob_dis,
    input  logic [N_CH-1:0]   chan_en,
    input  logic [N_CH-1:0]   sync_stop,
    input  logic [2*N_CH-1:0] dis_level,
    output logic [N_CH-1:0]   pad_data,
    output logic [N_CH-1:0]   pad_oe
);

    localparam int LVL_W = $bits(off_lvl_e);

    pad_drv_t drv [N_CH];

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        clkout_gate_chan #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_chan (
            .src_clk  (src_clk[i]),
            .rst      (rst),
            .glob_off (glob_dis),
            .chan_on  (chan_en[i]),
            .sync_stop(sync_stop[i]),
            .off_lvl  (off_lvl_e'(dis_level[LVL_W*i +: LVL_W])),
            .drv      (drv[i])
        );
        assign pad_data[i] = drv[i].data;
        assign pad_oe[i]   = drv[i].oe;
    end

endmodule

// File: tb/clkout_gate_bank_bench.sv
module clkout_gate_bank_bench;

    localparam int N = 10;

    logic           clk = 1'b0;
    logic           rst;
    logic           glob_dis;
    logic [N-1:0]   chan_en;
    logic [N-1:0]   sync_stop;
    logic [2*N-1:0] dis_level;
    logic [N-1:0]   pad_data;
    logic [N-1:0]   pad_oe;

    always #5 clk = ~clk;

    clkout_gate_bank #(.N_CH(N)) u_clkout_gate_bank (
        .src_clk  ({N{clk}}),
        .rst      (rst),
        .glob_dis (glob_dis),
        .chan_en  (chan_en),
        .sync_stop(sync_stop),
        .dis_level(dis_level),
        .pad_data (pad_data),
        .pad_oe   (pad_oe)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        logic [N-1:0] run;
        string        tag;
    } exp_t;
    exp_t q[$];

    // expected pad values from R3 and R7
    function automatic logic [N-1:0] exp_data(input logic [N-1:0] run, input logic hi);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++)
            r[i] = run[i] ? hi : (dis_level[2*i +: 2] == 2'b01);
        return r;
    endfunction

    function automatic logic [N-1:0] exp_oe(input logic [N-1:0] run);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++)
            r[i] = run[i] | (dis_level[2*i+1] == 1'b0);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item and checks both clock phases
    initial begin
        forever begin
            exp_t it;
            wait (q.size() > 0);
            it = q[0];
            @(posedge clk); #2;
            chk({it.tag, " data high phase"}, pad_data, exp_data(it.run, 1'b1));
            chk({it.tag, " oe"}, pad_oe, exp_oe(it.run));
            @(negedge clk); #2;
            chk({it.tag, " data low phase"}, pad_data, exp_data(it.run, 1'b0));
            void'(q.pop_front());
        end
    end

    task automatic expect_run(input logic [N-1:0] run, input string tag);
        exp_t it;
        it.run = run;
        it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic set_all_levels(input logic [1:0] lvl);
        for (int i = 0; i < N; i++) dis_level[2*i +: 2] = lvl;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..R8 actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        rst       = 1'b1;
        glob_dis  = 1'b0;
        chan_en   = '1;
        for (int i = 0; i < N; i++) sync_stop[i] = (i % 2 == 0);
        for (int i = 0; i < N; i++) dis_level[2*i +: 2] = 2'(i % 4);

        // R8: idle during reset, even with every enable set
        settle();
        expect_run('0, "R8 during reset");
        @(negedge clk); #1;
        rst = 1'b0;
        @(posedge clk); #2;
        chk("R8 first edge after reset", pad_data, exp_data('0, 1'b1));

        // R7: all running, pads follow the clock
        settle();
        expect_run('1, "R7 all running");

        // R1: pin overrides every enable bit
        glob_dis = 1'b1;
        settle();
        expect_run('0, "R1 global disable");

        // R2: per-channel mask
        glob_dis = 1'b0;
        chan_en  = 10'b1010011001;
        settle();
        expect_run(10'b1010011001, "R2 channel mask");

        // R3: each idle code on all channels
        chan_en = '0;
        set_all_levels(2'b00); settle(); expect_run('0, "R3 code 00 low");
        set_all_levels(2'b01); settle(); expect_run('0, "R3 code 01 high");
        set_all_levels(2'b10); settle(); expect_run('0, "R3 code 10 floating");
        set_all_levels(2'b11); settle(); expect_run('0, "R3 code 11 floating");

        // R4 / R5: stop timing, even channels period-completing, odd immediate
        set_all_levels(2'b00);
        chan_en = '1;
        settle();
        @(negedge clk); #1;
        chan_en = '0;
        @(posedge clk); #2;
        chk("R4 R5 first edge still running", pad_data, '1);
        @(posedge clk); #2;
        chk("R4 R5 second edge sync keeps pulse, immediate cut", pad_data, sync_stop);
        @(negedge clk); #2;
        chk("R4 low phase after stop", pad_data, '0);
        @(posedge clk); #2;
        chk("R4 third edge all idle", pad_data, '0);
        chk("R3 idle low keeps oe", pad_oe, '1);

        // R6: restart only at a falling edge
        @(negedge clk); #1;
        chan_en = '1;
        @(posedge clk); #2;
        chk("R6 first edge still idle", pad_data, '0);
        @(posedge clk); #2;
        chk("R6 second edge still idle", pad_data, '0);
        @(posedge clk); #2;
        chk("R6 third edge full pulse", pad_data, '1);

        done = 1;
        finish_run();
    end

endmodule